// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle 32-bit core that runs a small subset of the RISC-V integer instructions: word load and store, ten register-register ALU operations, a modified add-immediate, branch-if-equal and jump-and-link. Each instruction takes between three and five clock cycles. On every cycle the sequencer issues the write strobes and multiplexer selects that drive a separate datapath. Its inputs are the opcode and function fields held in the instruction register, plus the equality flag that the datapath's ALU produces.

Every instruction starts with a fetch cycle and a decode cycle. The fetch cycle latches the instruction, saves the current PC into a PC-copy register and advances the PC by four. The decode cycle lets the datapath read the source registers and form the branch target ahead of time. After decode the sequencer branches into a short per-class path and then returns to fetch. The modified add-immediate is finished in a single dedicated state. That state writes the bitwise inverse of `rs1 + imm` to the destination register. An opcode or function combination that is not recognised goes straight back to fetch and issues no write.

The reset input is asynchronous and active low. Assertion takes effect at once. Release passes through a synchronizer before the sequencer starts.

Top module: `mcyc_ctl_seq`

## Requirements
- R1: While `rst_n` is low, `pc_we_o`, `ir_we_o`, `pcc_we_o`, `rf_we_o`, `mem_rd_o` and `mem_wr_o` are all low, and a fall of `rst_n` forces them low without waiting for a clock edge. After `rst_n` rises, they stay low through the first rising edge. The fetch outputs appear after the second rising edge.
- R2: The fetch state drives `pc_we_o`=1, `pc_src_o`=0 (live ALU result), `ir_we_o`=1, `pcc_we_o`=1, `alu_a_sel_o`=0 (PC), `alu_b_sel_o`=1 (constant 4) and `alu_op_o`=4'b0000 (add). Every other output is 0, and the next state is always decode.
- R3: The decode state issues no write strobe and no memory access. It drives `alu_a_sel_o`=1 (PC copy), `alu_b_sel_o`=2 (immediate), `imm_sel_o`=2 (B format) and `alu_op_o`=add.
- R4: A load (opcode 7'b0000011, funct3 3'b010) runs through three states after decode, then returns to fetch. The address state drives `alu_a_sel_o`=2 (register A), `alu_b_sel_o`=2 and `imm_sel_o`=0 (I format). The read state drives `mem_rd_o`=1. The write-back state drives `rf_we_o`=1 with `wb_sel_o`=1 (memory data register).
- R5: A store (opcode 7'b0100011, funct3 3'b010) runs through the address state with `imm_sel_o`=1 (S format), then a state with `mem_wr_o`=1, then returns to fetch. No register write occurs.
- R6: A register-register operation (opcode 7'b0110011) executes with `alu_a_sel_o`=2, `alu_b_sel_o`=0 (register B) and `alu_op_o`={funct7[5], funct3}. The next state writes back with `rf_we_o`=1 and `wb_sel_o`=0 (ALU output register), then the sequencer returns to fetch. Valid combinations are funct7=0 with any funct3, and funct7=7'b0100000 with funct3 3'b000 or 3'b101.
- R7: The add-immediate (opcode 7'b0010011, funct3 3'b000) takes one state after decode. That state drives `alu_a_sel_o`=2, `alu_b_sel_o`=2, `imm_sel_o`=0, add, `rf_we_o`=1 and `wb_sel_o`=2 (inverted live ALU result), then returns to fetch.
- R8: Branch-if-equal (opcode 7'b1100011, funct3 3'b000) takes one state after decode. That state drives `alu_op_o`=4'b1000 (subtract) on register A and register B, and `pc_src_o`=1 (ALU output register). `pc_we_o` equals `eq_i` in the same cycle. The sequencer then returns to fetch.
- R9: Jump-and-link (opcode 7'b1101111) takes one state after decode. That state drives `alu_a_sel_o`=1, `alu_b_sel_o`=2, `imm_sel_o`=3 (J format), add, `pc_we_o`=1 with `pc_src_o`=0, `rf_we_o`=1 and `wb_sel_o`=3 (PC copy plus 4), then returns to fetch.
- R10: Any other opcode, or a listed opcode with a funct3 or funct7 outside the combinations above, returns from decode to fetch on the next cycle with no write strobe asserted.
- R11: At most one of `rf_we_o`, `mem_rd_o` and `mem_wr_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| opcode_i | input | 7 | Opcode field of the instruction register |
| funct3_i | input | 3 | funct3 field of the instruction register |
| funct7_i | input | 7 | funct7 field of the instruction register |
| eq_i | input | 1 | Datapath flag: the two ALU operands are equal |
| pc_we_o | output | 1 | PC write enable |
| pc_src_o | output | 1 | PC source: 0 live ALU result, 1 ALU output register |
| ir_we_o | output | 1 | Instruction register write enable |
| pcc_we_o | output | 1 | PC-copy register write enable |
| rf_we_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_wr_o | output | 1 | Data memory write strobe |
| alu_op_o | output | 4 | ALU operation, {funct7[5], funct3} encoding |
| alu_a_sel_o | output | 2 | ALU A operand: 0 PC, 1 PC copy, 2 register A |
| alu_b_sel_o | output | 2 | ALU B operand: 0 register B, 1 constant 4, 2 immediate |
| imm_sel_o | output | 2 | Immediate format: 0 I, 1 S, 2 B, 3 J |
| wb_sel_o | output | 2 | Write-back source: 0 ALU out reg, 1 memory data, 2 inverted ALU, 3 PC copy + 4 |

## Verification
The assertions check several ordering rules on every cycle:
- fetch is always followed by decode;
- decode never writes;
- a memory read is followed by a memory-data write-back;
- every register write or memory write ends the instruction;
- a PC load from the ALU output register happens only in the cycle after decode;
- the three data-access strobes are mutually exclusive;
- reset keeps all strobes low.

Other behaviours can only be shown by the bench's scenarios, because they depend on the exact field decode:
- the full per-cycle output signature of each instruction class;
- the `{funct7[5], funct3}` operation code;
- the choice of S or I format in the address state;
- the equality-dependent branch write;
- the rejection of near-miss encodings such as a shift-immediate, a byte load or a funct7 for multiply.

The bench also shows the two-edge release after reset and the asynchronous return to a quiet state in the middle of a load.

// File: rtl/mcyc_ctl_pkg.sv
package mcyc_ctl_pkg;

  localparam int OPC_W   = 7;
  localparam int F3_W    = 3;
  localparam int F7_W    = 7;
  localparam int ALUOP_W = F3_W + 1;
  localparam int SEL_W   = 2;
  localparam int F7_ALT_BIT = 5;

  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_REGREG = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JUMP   = 7'b1101111;

  localparam logic [F3_W-1:0] F3_WORD  = 3'b010;
  localparam logic [F3_W-1:0] F3_ADD   = 3'b000;
  localparam logic [F3_W-1:0] F3_SHR   = 3'b101;
  localparam logic [F3_W-1:0] F3_EQ    = 3'b000;
  localparam logic [F7_W-1:0] F7_BASE  = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT   = 7'b0100000;

  localparam logic [ALUOP_W-1:0] ALU_ADD = 4'b0000;
  localparam logic [ALUOP_W-1:0] ALU_SUB = 4'b1000;

  localparam logic [SEL_W-1:0] A_PC   = 2'd0;
  localparam logic [SEL_W-1:0] A_PCC  = 2'd1;
  localparam logic [SEL_W-1:0] A_REG  = 2'd2;
  localparam logic [SEL_W-1:0] B_REG  = 2'd0;
  localparam logic [SEL_W-1:0] B_FOUR = 2'd1;
  localparam logic [SEL_W-1:0] B_IMM  = 2'd2;
  localparam logic [SEL_W-1:0] IMM_I  = 2'd0;
  localparam logic [SEL_W-1:0] IMM_S  = 2'd1;
  localparam logic [SEL_W-1:0] IMM_B  = 2'd2;
  localparam logic [SEL_W-1:0] IMM_J  = 2'd3;
  localparam logic [SEL_W-1:0] WB_ALUOUT = 2'd0;
  localparam logic [SEL_W-1:0] WB_MDR    = 2'd1;
  localparam logic [SEL_W-1:0] WB_ALUINV = 2'd2;
  localparam logic [SEL_W-1:0] WB_LINK   = 2'd3;
  localparam logic PCS_ALU    = 1'b0;
  localparam logic PCS_ALUOUT = 1'b1;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_MEM_ADDR, ST_LOAD_RD, ST_LOAD_WB, ST_STORE_WR,
    ST_ALU_EXEC, ST_ALU_WB, ST_BRANCH, ST_JUMP, ST_ADDI_INV
  } ctl_state_e;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_LOAD, CLS_STORE, CLS_ALU, CLS_ADDI, CLS_BRANCH, CLS_JUMP
  } ctl_class_e;

endpackage

// File: rtl/mcyc_rst_sync.sv
module mcyc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  localparam logic [STAGES-1:0] ONE = STAGES'(1);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= (shift_q << 1) | ONE;
  end

  assign rst_s_n = shift_q[STAGES-1];
endmodule

// File: rtl/mcyc_ctl_decode.sv
module mcyc_ctl_decode
  import mcyc_ctl_pkg::*;
(
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic [F3_W-1:0]    funct3_i,
  input  logic [F7_W-1:0]    funct7_i,
  output ctl_class_e         cls_o,
  output logic [ALUOP_W-1:0] r_op_o
);
  logic rr_ok;

  always_comb begin
    rr_ok  = (funct7_i == F7_BASE) ||
             ((funct7_i == F7_ALT) && ((funct3_i == F3_ADD) || (funct3_i == F3_SHR)));
    r_op_o = {funct7_i[F7_ALT_BIT], funct3_i};
    cls_o  = CLS_NONE;
    case (opcode_i)
      OPC_LOAD:   if (funct3_i == F3_WORD) cls_o = CLS_LOAD;
      OPC_STORE:  if (funct3_i == F3_WORD) cls_o = CLS_STORE;
      OPC_REGREG: if (rr_ok)               cls_o = CLS_ALU;
      OPC_IMM:    if (funct3_i == F3_ADD)  cls_o = CLS_ADDI;
      OPC_BRANCH: if (funct3_i == F3_EQ)   cls_o = CLS_BRANCH;
      OPC_JUMP:                            cls_o = CLS_JUMP;
      default:                             cls_o = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/mcyc_ctl_next.sv
module mcyc_ctl_next
  import mcyc_ctl_pkg::*;
(
  input  ctl_state_e state_i,
  input  ctl_class_e cls_i,
  output ctl_state_e state_nxt_o
);
  always_comb begin
    state_nxt_o = ST_FETCH;
    case (state_i)
      ST_FETCH:    state_nxt_o = ST_DECODE;
      ST_DECODE: begin
        case (cls_i)
          CLS_LOAD, CLS_STORE: state_nxt_o = ST_MEM_ADDR;
          CLS_ALU:             state_nxt_o = ST_ALU_EXEC;
          CLS_ADDI:            state_nxt_o = ST_ADDI_INV;
          CLS_BRANCH:          state_nxt_o = ST_BRANCH;
          CLS_JUMP:            state_nxt_o = ST_JUMP;
          default:             state_nxt_o = ST_FETCH;
        endcase
      end
      ST_MEM_ADDR: state_nxt_o = (cls_i == CLS_STORE) ? ST_STORE_WR : ST_LOAD_RD;
      ST_LOAD_RD:  state_nxt_o = ST_LOAD_WB;
      ST_ALU_EXEC: state_nxt_o = ST_ALU_WB;
      default:     state_nxt_o = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcyc_ctl_strobes.sv
module mcyc_ctl_strobes
  import mcyc_ctl_pkg::*;
(
  input  logic               run_i,
  input  ctl_state_e         state_i,
  input  ctl_class_e         cls_i,
  input  logic [ALUOP_W-1:0] r_op_i,
  input  logic               eq_i,
  output logic               pc_we_o,
  output logic               pc_src_o,
  output logic               ir_we_o,
  output logic               pcc_we_o,
  output logic               rf_we_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [ALUOP_W-1:0] alu_op_o,
  output logic [SEL_W-1:0]   alu_a_sel_o,
  output logic [SEL_W-1:0]   alu_b_sel_o,
  output logic [SEL_W-1:0]   imm_sel_o,
  output logic [SEL_W-1:0]   wb_sel_o
);
  always_comb begin
    pc_we_o = 1'b0; pc_src_o = PCS_ALU; ir_we_o = 1'b0; pcc_we_o = 1'b0;
    rf_we_o = 1'b0; mem_rd_o = 1'b0; mem_wr_o = 1'b0;
    alu_op_o = ALU_ADD; alu_a_sel_o = A_PC; alu_b_sel_o = B_REG;
    imm_sel_o = IMM_I; wb_sel_o = WB_ALUOUT;
    case (state_i)
      ST_FETCH: begin
        ir_we_o = 1'b1; pcc_we_o = 1'b1; pc_we_o = 1'b1;
        alu_b_sel_o = B_FOUR;
      end
      ST_DECODE: begin
        alu_a_sel_o = A_PCC; alu_b_sel_o = B_IMM; imm_sel_o = IMM_B;
      end
      ST_MEM_ADDR: begin
        alu_a_sel_o = A_REG; alu_b_sel_o = B_IMM;
        imm_sel_o = (cls_i == CLS_STORE) ? IMM_S : IMM_I;
      end
      ST_LOAD_RD:  mem_rd_o = 1'b1;
      ST_LOAD_WB:  begin rf_we_o = 1'b1; wb_sel_o = WB_MDR; end
      ST_STORE_WR: mem_wr_o = 1'b1;
      ST_ALU_EXEC: begin alu_a_sel_o = A_REG; alu_op_o = r_op_i; end
      ST_ALU_WB:   rf_we_o = 1'b1;
      ST_BRANCH: begin
        alu_a_sel_o = A_REG; alu_op_o = ALU_SUB;
        pc_src_o = PCS_ALUOUT; pc_we_o = eq_i;
      end
      ST_JUMP: begin
        alu_a_sel_o = A_PCC; alu_b_sel_o = B_IMM; imm_sel_o = IMM_J;
        pc_we_o = 1'b1; rf_we_o = 1'b1; wb_sel_o = WB_LINK;
      end
      ST_ADDI_INV: begin
        alu_a_sel_o = A_REG; alu_b_sel_o = B_IMM;
        rf_we_o = 1'b1; wb_sel_o = WB_ALUINV;
      end
      default: ;
    endcase
    if (!run_i) begin
      pc_we_o = 1'b0; ir_we_o = 1'b0; pcc_we_o = 1'b0;
      rf_we_o = 1'b0; mem_rd_o = 1'b0; mem_wr_o = 1'b0;
    end
  end

  always_comb begin
    if (!run_i) begin
      AST_RST_QUIET: assert (!(pc_we_o || ir_we_o || pcc_we_o || rf_we_o || mem_rd_o || mem_wr_o)); // R1
    end
  end
endmodule

// File: rtl/mcyc_ctl_seq.sv
module mcyc_ctl_seq
  import mcyc_ctl_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic [F3_W-1:0]    funct3_i,
  input  logic [F7_W-1:0]    funct7_i,
  input  logic               eq_i,
  output logic               pc_we_o,
  output logic               pc_src_o,
  output logic               ir_we_o,
  output logic               pcc_we_o,
  output logic               rf_we_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [ALUOP_W-1:0] alu_op_o,
  output logic [SEL_W-1:0]   alu_a_sel_o,
  output logic [SEL_W-1:0]   alu_b_sel_o,
  output logic [SEL_W-1:0]   imm_sel_o,
  output logic [SEL_W-1:0]   wb_sel_o
);
  logic               rst_s_n;
  ctl_state_e         state_q;
  ctl_state_e         state_nxt;
  ctl_class_e         cls;
  logic [ALUOP_W-1:0] r_op;

  mcyc_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  mcyc_ctl_decode u_decode (
    .opcode_i(opcode_i), .funct3_i(funct3_i), .funct7_i(funct7_i),
    .cls_o(cls), .r_op_o(r_op)
  );

  mcyc_ctl_next u_next (
    .state_i(state_q), .cls_i(cls), .state_nxt_o(state_nxt)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) state_q <= ST_FETCH;
    else          state_q <= state_nxt;
  end

  mcyc_ctl_strobes u_strobes (
    .run_i(rst_s_n), .state_i(state_q), .cls_i(cls), .r_op_i(r_op), .eq_i(eq_i),
    .pc_we_o(pc_we_o), .pc_src_o(pc_src_o), .ir_we_o(ir_we_o), .pcc_we_o(pcc_we_o),
    .rf_we_o(rf_we_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .alu_op_o(alu_op_o), .alu_a_sel_o(alu_a_sel_o), .alu_b_sel_o(alu_b_sel_o),
    .imm_sel_o(imm_sel_o), .wb_sel_o(wb_sel_o)
  );

  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_s_n)
    state_q == ST_FETCH |=> state_q == ST_DECODE); // R2
  AST_DECODE_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    state_q == ST_DECODE |-> !(pc_we_o || ir_we_o || rf_we_o || mem_rd_o || mem_wr_o)); // R3
  AST_LOAD_ORDER: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_rd_o |=> rf_we_o && wb_sel_o == WB_MDR); // R4
  AST_RF_WRITE_ENDS: assert property (@(posedge clk) disable iff (!rst_s_n)
    rf_we_o |=> state_q == ST_FETCH); // R4
  AST_STORE_ENDS: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_wr_o |=> state_q == ST_FETCH && !rf_we_o); // R5
  AST_BRANCH_SLOT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pc_we_o && pc_src_o == PCS_ALUOUT) |-> $past(state_q) == ST_DECODE); // R8
  AST_UNKNOWN_RETURNS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_DECODE && cls == CLS_NONE) |=> state_q == ST_FETCH); // R10
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({rf_we_o, mem_rd_o, mem_wr_o})); // R11
endmodule

// File: tb/test_mcyc_ctl_seq.sv
module test_mcyc_ctl_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic [6:0] opcode;
  logic [2:0] funct3;
  logic [6:0] funct7;
  logic eq;
  logic pc_we, pc_src, ir_we, pcc_we, rf_we, mem_rd, mem_wr;
  logic [3:0] alu_op;
  logic [1:0] a_sel, b_sel, imm_sel, wb_sel;

  int checks = 0;
  int errors = 0;
  int multi_access = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mcyc_ctl_seq i_mcyc_ctl_seq (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .funct3_i(funct3), .funct7_i(funct7),
    .eq_i(eq), .pc_we_o(pc_we), .pc_src_o(pc_src), .ir_we_o(ir_we), .pcc_we_o(pcc_we),
    .rf_we_o(rf_we), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .alu_op_o(alu_op),
    .alu_a_sel_o(a_sel), .alu_b_sel_o(b_sel), .imm_sel_o(imm_sel), .wb_sel_o(wb_sel)
  );

  localparam int S_FETCH = 0, S_DEC = 1, S_ADDR = 2, S_LRD = 3, S_LWB = 4, S_SWR = 5;
  localparam int S_RX = 6, S_RWB = 7, S_BEQ = 8, S_JAL = 9, S_ADDI = 10, S_END = 15;

  // opcode, funct3, funct7, eq, path of up to four states after decode
  localparam int NV = 17;
  localparam logic [33:0] VEC [NV] = '{
    {7'b0000011, 3'b010, 7'h00, 1'b0, 16'h234F},  // load
    {7'b0100011, 3'b010, 7'h00, 1'b0, 16'h25FF},  // store
    {7'b0110011, 3'b000, 7'h00, 1'b0, 16'h67FF},  // add
    {7'b0110011, 3'b000, 7'h20, 1'b0, 16'h67FF},  // sub
    {7'b0110011, 3'b101, 7'h20, 1'b0, 16'h67FF},  // sra
    {7'b0110011, 3'b111, 7'h00, 1'b1, 16'h67FF},  // and
    {7'b0110011, 3'b011, 7'h00, 1'b0, 16'h67FF},  // sltu
    {7'b0010011, 3'b000, 7'h00, 1'b1, 16'hAFFF},  // addi inverted
    {7'b1100011, 3'b000, 7'h00, 1'b1, 16'h8FFF},  // beq taken
    {7'b1100011, 3'b000, 7'h00, 1'b0, 16'h8FFF},  // beq not taken
    {7'b1101111, 3'b110, 7'h11, 1'b0, 16'h9FFF},  // jal
    {7'b1111111, 3'b000, 7'h00, 1'b0, 16'hFFFF},  // unknown opcode
    {7'b0010011, 3'b001, 7'h00, 1'b0, 16'hFFFF},  // shift-immediate
    {7'b0110011, 3'b001, 7'h20, 1'b0, 16'hFFFF},  // bad funct7 pairing
    {7'b1100011, 3'b001, 7'h00, 1'b1, 16'hFFFF},  // bne
    {7'b0000011, 3'b000, 7'h00, 1'b0, 16'hFFFF},  // byte load
    {7'b0110011, 3'b000, 7'h01, 1'b0, 16'hFFFF}   // multiply funct7
  };

  function automatic logic [18:0] got_word();
    return {pc_we, pc_src, ir_we, pcc_we, rf_we, mem_rd, mem_wr, alu_op, a_sel, b_sel, imm_sel, wb_sel};
  endfunction

  function automatic logic [5:0] strobes_of(logic [18:0] w);
    return {w[18], w[16:12]};
  endfunction

  // word: pc_we pc_src ir pcc rf rd wr op[4] a[2] b[2] imm[2] wb[2]
  function automatic logic [18:0] exp_word(int id, logic [3:0] rop, logic st, logic e);
    case (id)
      S_FETCH: return {1'b1, 1'b0, 1'b1, 1'b1, 3'b000, 4'h0, 2'd0, 2'd1, 2'd0, 2'd0};
      S_DEC:   return {4'b0000, 3'b000, 4'h0, 2'd1, 2'd2, 2'd2, 2'd0};
      S_ADDR:  return {4'b0000, 3'b000, 4'h0, 2'd2, 2'd2, (st ? 2'd1 : 2'd0), 2'd0};
      S_LRD:   return {4'b0000, 3'b010, 4'h0, 2'd0, 2'd0, 2'd0, 2'd0};
      S_LWB:   return {4'b0000, 3'b100, 4'h0, 2'd0, 2'd0, 2'd0, 2'd1};
      S_SWR:   return {4'b0000, 3'b001, 4'h0, 2'd0, 2'd0, 2'd0, 2'd0};
      S_RX:    return {4'b0000, 3'b000, rop, 2'd2, 2'd0, 2'd0, 2'd0};
      S_RWB:   return {4'b0000, 3'b100, 4'h0, 2'd0, 2'd0, 2'd0, 2'd0};
      S_BEQ:   return {e, 1'b1, 2'b00, 3'b000, 4'h8, 2'd2, 2'd0, 2'd0, 2'd0};
      S_JAL:   return {1'b1, 1'b0, 2'b00, 3'b100, 4'h0, 2'd1, 2'd2, 2'd3, 2'd3};
      S_ADDI:  return {4'b0000, 3'b100, 4'h0, 2'd2, 2'd2, 2'd0, 2'd2};
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(int id, logic st);
    case (id)
      S_FETCH: return "R2";
      S_DEC:   return "R3";
      S_ADDR:  return st ? "R5" : "R4";
      S_LRD, S_LWB: return "R4";
      S_SWR:   return "R5";
      S_RX, S_RWB: return "R6";
      S_BEQ:   return "R8";
      S_JAL:   return "R9";
      S_ADDI:  return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [18:0] got, logic [18:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s: got %05h expected %05h", tag, got, expv);
    end
  endtask

  task automatic tally();
    if ((32'(rf_we) + 32'(mem_rd) + 32'(mem_wr)) > 1) multi_access++;
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic prev_none;
    logic [33:0] v;
    logic st;
    logic [3:0] rop;
    rst_n = 1'b0; opcode = '0; funct3 = '0; funct7 = '0; eq = 1'b0;
    prev_none = 1'b0;

    repeat (3) @(negedge clk);
    #1 chk("R1 in reset", {13'b0, strobes_of(got_word())}, 19'b0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R1 first edge after release", {13'b0, strobes_of(got_word())}, 19'b0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      @(negedge clk);
      opcode = v[33:27]; funct3 = v[26:24]; funct7 = v[23:17]; eq = v[16];
      st = (v[33:27] == 7'b0100011);
      rop = {v[22], v[26:24]};
      #1 chk(prev_none ? "R10 return" : (i == 0 ? "R1 release" : "R2"), got_word(), exp_word(S_FETCH, rop, st, eq));
      tally();
      @(negedge clk);
      #1 chk("R3", got_word(), exp_word(S_DEC, rop, st, eq));
      tally();
      prev_none = (v[15:12] == 4'hF);
      for (int k = 0; k < 4; k++) begin
        int id;
        id = int'(v[15 - 4*k -: 4]);
        if (id == S_END) break;
        @(negedge clk);
        #1 chk(tag_of(id, st), got_word(), exp_word(id, rop, st, eq));
        tally();
      end
    end
    @(negedge clk);
    #1 chk("R10 return", got_word(), exp_word(S_FETCH, 4'h0, 1'b0, 1'b0));
    checks++;
    if (multi_access != 0) begin
      errors++;
      $display("FAIL R11: got %0d multi-access cycles expected 0", multi_access);
    end

    // reset in the middle of a load
    opcode = 7'b0000011; funct3 = 3'b010; funct7 = '0;
    repeat (3) @(negedge clk);
    #1 chk("R4 read before reset", got_word(), exp_word(S_LRD, 4'h0, 1'b0, 1'b0));
    rst_n = 1'b0;
    #1 chk("R1 async assert", {13'b0, strobes_of(got_word())}, 19'b0);
    repeat (2) @(negedge clk);
    #1 chk("R1 held", {13'b0, strobes_of(got_word())}, 19'b0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R1 first edge after release", {13'b0, strobes_of(got_word())}, 19'b0);
    @(negedge clk);
    #1 chk("R1 restart at fetch", got_word(), exp_word(S_FETCH, 4'h0, 1'b0, 1'b0));

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule